// File: doc/BRIEF.md
# SMBus Host Register Front-End

This block is the software-facing register file of an I2C/SMBus host controller. A 32-bit single-cycle read/write bus reaches four registers. The first is a port that queues command words for the serial engine. The second is a port that hands back bytes the engine has received. The third is a status register whose flags are cleared by writing ones. The fourth is a control register that holds the SCL clock divisor and two self-clearing flush strobes.

The block holds both queues. A command queue feeds the bus engine through a valid/pop handshake. A receive queue is filled by the engine one byte at a time. The engine reports finished transfers and missing acknowledges as single-cycle pulses, and these become sticky status flags. Software sequences a transaction in four steps: it clears status, pushes start/address/data/stop words, polls for the done flag, and then drains the receive port. It checks bit 8 of each receive read to detect an underrun.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, status reads 0, control reads 84 (0x54) in bits 7:0 with every other bit zero, `eng_clk_div` is 84, the command queue is empty (`eng_cmd_valid` low), and a read of the receive port returns 0x100.
- R2: A write to offset 0x00 queues bits 10:0 of the write data, where bits 7:0 are data or count, bit 8 is START, bit 9 is STOP and bit 10 is READ. Bits above 10 are discarded. The engine sees the words on `eng_cmd_data` in the order they were written.
- R3: The command queue holds 16 words. A write to offset 0x00 while it is full is dropped, leaves the queued words intact, and sets the sticky overflow flag in status bit 0.
- R4: A read of offset 0x04 returns the oldest received byte in bits 7:0 with bit 8 clear, and removes that byte. When the receive queue is empty, the read returns 0x100 and changes nothing.
- R5: A one-cycle `eng_done` pulse sets status bit 27, and a one-cycle `eng_nack` pulse sets status bit 21. Both flags stay set until software clears them.
- R6: A write to offset 0x14 clears each of status bits 27, 21 and 0 that is written as one, and leaves each bit written as zero unchanged. Writing back a value just read clears every flag that was pending.
- R7: When a set event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R8: A write to offset 0x1C stores bits 7:0 as the clock divisor. The divisor drives `eng_clk_div` from the next cycle and reads back in bits 7:0; 84 selects 100 kHz and 21 selects 400 kHz.
- R9: A control write with bit 9 set empties the command queue, and a control write with bit 10 set empties the receive queue. Each drives its strobe (`eng_tx_rst` or `eng_rx_rst`) high for exactly the one cycle after the write. Bits 9 and 10 always read back as zero.
- R10: The receive queue holds 16 bytes. An `eng_rx_push` while it is full is dropped, and the stored bytes are kept.
- R11: Reads of offsets other than 0x04, 0x14 and 0x1C return zero. Writes to offsets other than 0x00, 0x14 and 0x1C change no register, queue or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| eng_cmd_valid | output | 1 | Command queue not empty |
| eng_cmd_data | output | 11 | Oldest queued command word |
| eng_cmd_pop | input | 1 | Engine consumes the oldest command word |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_done | input | 1 | Single-cycle transfer-complete pulse |
| eng_nack | input | 1 | Single-cycle no-acknowledge pulse |
| eng_clk_div | output | 8 | SCL clock divisor |
| eng_tx_rst | output | 1 | One-cycle command-path reset strobe |
| eng_rx_rst | output | 1 | One-cycle receive-path reset strobe |

## Verification
The checker takes several things for granted. Each bus access lasts one cycle and touches one register. The engine pops only while `eng_cmd_valid` is high, and it raises `eng_done` and `eng_nack` only as pulses. The flush-strobe properties rely on the engine not refilling a queue during the cycle its strobe is high. The bench keeps within these assumptions: every access is framed by dropping `bus_sel` between cycles, the engine is modelled by tasks that pop only a visible word and pulse each event for one cycle, and engine pushes never overlap a flush.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;
    localparam int unsigned REG_AW = 5;
    localparam logic [REG_AW-1:0] OFS_TXCMD = 5'h00;
    localparam logic [REG_AW-1:0] OFS_RXDAT = 5'h04;
    localparam logic [REG_AW-1:0] OFS_STAT  = 5'h14;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h1C;

    localparam int unsigned CMD_W  = 11;
    localparam int unsigned BYTE_W = 8;

    localparam int unsigned ST_DONE_BIT  = 27;
    localparam int unsigned ST_NACK_BIT  = 21;
    localparam int unsigned ST_OVF_BIT   = 0;
    localparam int unsigned CTL_TXRST_BIT = 9;
    localparam int unsigned CTL_RXRST_BIT = 10;
    localparam int unsigned RX_EMPTY_BIT  = 8;

    typedef struct packed {
        logic done;
        logic nack;
        logic ovf;
    } stat_t;

    typedef struct packed {
        logic [BYTE_W-1:0] div;
        logic              tx_strobe;
        logic              rx_strobe;
    } ctl_t;
endpackage

// File: rtl/smb_fifo.sv
module smb_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (ptr_q.cnt == '0);
    assign full    = (ptr_q.cnt == CW'(DEPTH));
    assign count   = ptr_q.cnt;
    assign dout    = mem_q[ptr_q.rd];
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (do_push) ptr_d.wr = bump(ptr_q.wr);
            if (do_pop)  ptr_d.rd = bump(ptr_q.rd);
            case ({do_push, do_pop})
                2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
                2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
                default: ptr_d.cnt = ptr_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[ptr_q.wr] <= din;
    end
endmodule

// File: rtl/smb_status.sv
module smb_status
    import smb_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  set_done,
    input  logic  set_nack,
    input  logic  set_ovf,
    input  logic  clr_en,
    input  stat_t clr_mask,
    output stat_t stat
);
    stat_t stat_d, stat_q;

    always_comb begin
        stat_d      = stat_q;
        stat_d.done = set_done | (stat_q.done & ~(clr_en & clr_mask.done));
        stat_d.nack = set_nack | (stat_q.nack & ~(clr_en & clr_mask.nack));
        stat_d.ovf  = set_ovf  | (stat_q.ovf  & ~(clr_en & clr_mask.ovf));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_regs_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned DIV_RESET = 84
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_cmd_valid,
    output logic [10:0]       eng_cmd_data,
    input  logic              eng_cmd_pop,
    input  logic              eng_rx_push,
    input  logic [7:0]        eng_rx_data,
    input  logic              eng_done,
    input  logic              eng_nack,
    output logic [7:0]        eng_clk_div,
    output logic              eng_tx_rst,
    output logic              eng_rx_rst
);
    localparam int unsigned CW = $clog2(DEPTH+1);

    ctl_t ctl_d, ctl_q;
    stat_t stat_q;
    stat_t stat_clr_mask;

    logic wr_txcmd, wr_stat, wr_ctrl, rd_rxdat;
    logic tx_flush, rx_flush, tx_ovf_evt;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic [CW-1:0] tx_count, rx_count;
    logic [BYTE_W-1:0] rx_dout;
    logic unused_wbits;

    assign wr_txcmd = bus_sel &&  bus_wr && (bus_addr == OFS_TXCMD);
    assign wr_stat  = bus_sel &&  bus_wr && (bus_addr == OFS_STAT);
    assign wr_ctrl  = bus_sel &&  bus_wr && (bus_addr == OFS_CTRL);
    assign rd_rxdat = bus_sel && !bus_wr && (bus_addr == OFS_RXDAT);

    assign tx_flush   = wr_ctrl && bus_wdata[CTL_TXRST_BIT];
    assign rx_flush   = wr_ctrl && bus_wdata[CTL_RXRST_BIT];
    assign tx_ovf_evt = wr_txcmd && tx_full;

    assign stat_clr_mask.done = bus_wdata[ST_DONE_BIT];
    assign stat_clr_mask.nack = bus_wdata[ST_NACK_BIT];
    assign stat_clr_mask.ovf  = bus_wdata[ST_OVF_BIT];
    assign unused_wbits = ^{bus_wdata[31:28], bus_wdata[26:22], bus_wdata[20:11],
                            rx_full, tx_count, rx_count};

    smb_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (wr_txcmd),
        .pop   (eng_cmd_pop),
        .din   (bus_wdata[CMD_W-1:0]),
        .dout  (eng_cmd_data),
        .empty (tx_empty),
        .full  (tx_full),
        .count (tx_count)
    );

    smb_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (eng_rx_push),
        .pop   (rd_rxdat),
        .din   (eng_rx_data),
        .dout  (rx_dout),
        .empty (rx_empty),
        .full  (rx_full),
        .count (rx_count)
    );

    smb_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_done (eng_done),
        .set_nack (eng_nack),
        .set_ovf  (tx_ovf_evt),
        .clr_en   (wr_stat),
        .clr_mask (stat_clr_mask),
        .stat     (stat_q)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.tx_strobe = tx_flush;
        ctl_d.rx_strobe = rx_flush;
        if (wr_ctrl) ctl_d.div = bus_wdata[BYTE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.div       <= BYTE_W'(DIV_RESET);
            ctl_q.tx_strobe <= 1'b0;
            ctl_q.rx_strobe <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_RXDAT: begin
                    if (rx_empty) bus_rdata[RX_EMPTY_BIT] = 1'b1;
                    else          bus_rdata[BYTE_W-1:0]   = rx_dout;
                end
                OFS_STAT: begin
                    bus_rdata[ST_DONE_BIT] = stat_q.done;
                    bus_rdata[ST_NACK_BIT] = stat_q.nack;
                    bus_rdata[ST_OVF_BIT]  = stat_q.ovf;
                end
                OFS_CTRL: bus_rdata[BYTE_W-1:0] = ctl_q.div;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign eng_cmd_valid = !tx_empty;
    assign eng_clk_div   = ctl_q.div;
    assign eng_tx_rst    = ctl_q.tx_strobe;
    assign eng_rx_rst    = ctl_q.rx_strobe;
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk
    import smb_regs_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        eng_done,
    input logic                        eng_nack,
    input logic                        eng_tx_rst,
    input logic                        eng_rx_rst,
    input logic                        eng_cmd_valid,
    input logic                        eng_rx_push,
    input logic                        tx_push,
    input logic                        tx_full,
    input logic                        rx_pop,
    input stat_t                       st,
    input logic [$clog2(DEPTH+1)-1:0]  tx_count,
    input logic [$clog2(DEPTH+1)-1:0]  rx_count
);
    localparam int unsigned CW = $clog2(DEPTH+1);

    // R5
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> st.done);

    // R5
    nack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_nack |=> st.nack);

    // R3
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full) |=> st.ovf);

    // R3
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH));

    // R10
    rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    // R9
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_rst |-> !eng_cmd_valid);

    // R9
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rx_rst |-> (rx_count == '0));

    // R4
    rx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_count == '0 && !eng_rx_push) |=> (rx_count == '0));
endmodule

bind smb_host_regs smb_host_regs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .eng_done      (eng_done),
    .eng_nack      (eng_nack),
    .eng_tx_rst    (eng_tx_rst),
    .eng_rx_rst    (eng_rx_rst),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_rx_push   (eng_rx_push),
    .tx_push       (wr_txcmd),
    .tx_full       (tx_full),
    .rx_pop        (rd_rxdat),
    .st            (stat_q),
    .tx_count      (tx_count),
    .rx_count      (rx_count)
);

// File: tb/smb_host_regs_tb.sv
`timescale 1ns/1ps
module smb_host_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_cmd_valid;
    logic [10:0] eng_cmd_data;
    logic        eng_cmd_pop = 1'b0;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0]  eng_clk_div;
    logic        eng_tx_rst, eng_rx_rst;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    localparam logic [4:0] A_TX = 5'h00, A_RX = 5'h04, A_ST = 5'h14, A_CT = 5'h1C;
    localparam logic [31:0] DONE_M = 32'h0800_0000, NACK_M = 32'h0020_0000, OVF_M = 32'h1;

    always #10 clk = ~clk;

    smb_host_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd_data(eng_cmd_data),
        .eng_cmd_pop(eng_cmd_pop), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_clk_div(eng_clk_div), .eng_tx_rst(eng_tx_rst), .eng_rx_rst(eng_rx_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #5 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic eng_pop(output logic [10:0] w, output logic v);
        @(negedge clk);
        v = eng_cmd_valid; w = eng_cmd_data;
        eng_cmd_pop = 1'b1;
        @(posedge clk); #1;
        eng_cmd_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = b;
        @(posedge clk); #1;
        eng_rx_push = 1'b0;
    endtask

    task automatic pulse(input bit is_done);
        @(negedge clk);
        if (is_done) eng_done = 1'b1; else eng_nack = 1'b1;
        @(posedge clk); #1;
        eng_done = 1'b0; eng_nack = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [10:0] w;
        logic v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus_read(A_ST, r); check("R1 status", r, 32'h0);
        bus_read(A_CT, r); check("R1 control", r, 32'd84);
        bus_read(A_RX, r); check("R1 rx empty", r, 32'h100);
        check("R1 cmd_valid", {31'b0, eng_cmd_valid}, 32'h0);
        check("R1 clk_div", {24'b0, eng_clk_div}, 32'd84);

        // R2 / R3: fill command queue with high junk bits, then overflow
        for (int i = 0; i < 16; i++)
            bus_write(A_TX, 32'hFFFF_F800 | ((i * 149 + 7) & 32'h7FF));
        bus_read(A_ST, r); check("R3 no ovf at exactly full", r, 32'h0);
        bus_write(A_TX, 32'h0000_0555);
        bus_read(A_ST, r); check("R3 ovf set", r, OVF_M);
        for (int i = 0; i < 16; i++) begin
            eng_pop(w, v);
            check("R2 cmd valid", {31'b0, v}, 32'h1);
            check("R2 cmd word", {21'b0, w}, (i * 149 + 7) & 32'h7FF);
        end
        check("R3 dropped word absent", {31'b0, eng_cmd_valid}, 32'h0);
        bus_read(A_ST, r); check("R3 ovf sticky", r, OVF_M);
        bus_write(A_ST, r);
        bus_read(A_ST, r); check("R6 ovf cleared", r, 32'h0);

        // R4 / R10: receive queue fill, overflow drop, drain, underrun
        for (int i = 0; i < 16; i++) eng_push(8'((i * 53 + 11) & 8'hFF));
        eng_push(8'hEE);
        for (int i = 0; i < 16; i++) begin
            bus_read(A_RX, r);
            check("R10 R4 rx byte", r, (i * 53 + 11) & 32'hFF);
        end
        bus_read(A_RX, r); check("R4 underrun flag", r, 32'h100);
        bus_read(A_RX, r); check("R4 underrun repeat", r, 32'h100);
        eng_push(8'h3C);
        bus_read(A_RX, r); check("R4 after underrun", r, 32'h3C);

        // R5 / R6: sticky events and write-one-to-clear
        pulse(1'b1);
        bus_read(A_ST, r); check("R5 done", r, DONE_M);
        pulse(1'b0);
        bus_read(A_ST, r); check("R5 nack", r, DONE_M | NACK_M);
        bus_write(A_ST, 32'h0);
        bus_read(A_ST, r); check("R6 zero write keeps", r, DONE_M | NACK_M);
        bus_write(A_ST, DONE_M);
        bus_read(A_ST, r); check("R6 clear done only", r, NACK_M);
        pulse(1'b1);
        bus_read(A_ST, r);
        bus_write(A_ST, r);
        bus_read(A_ST, r); check("R6 write-back clears all", r, 32'h0);

        // R7: set wins over same-cycle clear
        pulse(1'b1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_ST; bus_wdata = DONE_M | NACK_M;
        eng_done = 1'b1;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; eng_done = 1'b0;
        bus_read(A_ST, r); check("R7 set beats clear", r, DONE_M);
        bus_write(A_ST, DONE_M);

        // R8: exhaustive divisor sweep
        for (int d = 0; d < 256; d++) begin
            bus_write(A_CT, 32'hFFFF_F800 | 32'(d));
            check("R8 eng_clk_div", {24'b0, eng_clk_div}, 32'(d));
            bus_read(A_CT, r);
            check("R8 readback", r, 32'(d));
        end

        // R9: command flush
        bus_write(A_TX, 32'h101);
        bus_write(A_TX, 32'h202);
        bus_write(A_CT, 32'h200 | 32'd21);
        check("R9 tx strobe high", {31'b0, eng_tx_rst}, 32'h1);
        check("R9 rx strobe idle", {31'b0, eng_rx_rst}, 32'h0);
        check("R9 tx queue empty", {31'b0, eng_cmd_valid}, 32'h0);
        @(posedge clk); #1;
        check("R9 tx strobe one cycle", {31'b0, eng_tx_rst}, 32'h0);
        bus_read(A_CT, r); check("R9 ctrl readback 400k", r, 32'd21);

        // R9: receive flush
        eng_push(8'h11);
        eng_push(8'h22);
        bus_write(A_CT, 32'h400 | 32'd84);
        check("R9 rx strobe high", {31'b0, eng_rx_rst}, 32'h1);
        @(posedge clk); #1;
        check("R9 rx strobe one cycle", {31'b0, eng_rx_rst}, 32'h0);
        bus_read(A_RX, r); check("R9 rx queue empty", r, 32'h100);
        bus_read(A_CT, r); check("R9 ctrl readback 100k", r, 32'd84);

        // R11: unmapped offsets
        pulse(1'b0);
        bus_write(A_TX, 32'h0AB);
        for (int a = 0; a < 32; a += 4) begin
            if (a != 0 && a != 5'h04 && a != 5'h14 && a != 5'h1C) begin
                bus_write(5'(a), 32'hFFFF_FFFF);
                bus_read(5'(a), r);
                check("R11 unmapped reads zero", r, 32'h0);
            end
        end
        bus_read(A_ST, r); check("R11 status untouched", r, NACK_M);
        bus_read(A_CT, r); check("R11 ctrl untouched", r, 32'd84);
        check("R11 no strobe", {30'b0, eng_tx_rst, eng_rx_rst}, 32'h0);
        eng_pop(w, v);
        check("R11 tx queue untouched", {20'b0, v, w}, 32'h8AB);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule